// File: doc/BRIEF.md
# Dual-View General Register File

This block holds sixty-four 64-bit general registers behind two combinational read ports and one synchronous write port. Each access carries its own view select. The full view reaches every register at its full width. The narrow view reaches only the lowest sixteen registers, as 32-bit quantities.

A narrow read returns the low half of the register with the upper half cleared. A narrow write replicates bit 31 of the data into the upper half before it stores the value. The highest register is a constant zero: reads of it give zero, and writes to it are discarded. An instruction pipeline uses the block as its integer register store and handles forwarding and hazards itself.

Top module: `gr_dualview_file`

## Requirements
- R1: When `rst` is high at a rising clock edge, every register is cleared to zero at that edge.
- R2: A full-view write (`wr_mode`=0, `wr_en`=1) to register 0..62 stores `wr_data` at the rising edge. A later full-view read of the same address returns that value.
- R3: A full-view read of address 63 always returns zero.
- R4: A write to address 63 changes no register. A later read of address 63 still returns zero, and all other registers keep their contents.
- R5: A narrow-view read (mode=1) returns bits 31:0 of the addressed register in data bits 31:0, with bits 63:32 zero.
- R6: A narrow-view write stores `wr_data[31:0]` in bits 31:0 and copies `wr_data[31]` into all of bits 63:32. Bits 63:32 of `wr_data` are not used.
- R7: In narrow view, address bits 5:4 are ignored. The register selected is address bits 3:0, so only registers 0..15 are reachable.
- R8: Reads are combinational. A read and a write that hit the same register in the same cycle return the value held before that clock edge.
- R9: The two read ports decode their address and mode independently. When `wr_en` is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| ra_addr | input | 6 | Read port A register address |
| ra_mode | input | 1 | Read port A view: 0 full, 1 narrow |
| ra_data | output | 64 | Read port A data |
| rb_addr | input | 6 | Read port B register address |
| rb_mode | input | 1 | Read port B view: 0 full, 1 narrow |
| rb_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 6 | Write register address |
| wr_mode | input | 1 | Write view: 0 full, 1 narrow |
| wr_data | input | 64 | Write data |

## Verification
The hardest case to reach from the ports is a narrow access whose address has nonzero upper bits. It must alias onto a low register, and it must interact correctly with full-view traffic to the same register. The random stimulus draws addresses across the whole 6-bit range in both views, and it weights address 63 and registers 0..15 heavily so that aliasing, the zero sink and same-cycle read-write collisions occur often. Directed steps add a negative narrow write read back in full view, and an aliased narrow read.

// File: rtl/gr_pkg.sv
package gr_pkg;
    localparam int NREGS   = 64;
    localparam int XLEN    = 64;
    localparam int NW      = 32;
    localparam int NARROWN = 16;
    localparam int IDX_W   = $clog2(NREGS);

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic {
        VIEW_FULL   = 1'b0,
        VIEW_NARROW = 1'b1
    } view_e;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t val;
    } wr_req_t;

    function automatic word_t narrow_to_reg(input word_t d);
        return {{(XLEN-NW){d[NW-1]}}, d[NW-1:0]};
    endfunction

    function automatic word_t reg_to_narrow(input word_t d);
        return {{(XLEN-NW){1'b0}}, d[NW-1:0]};
    endfunction
endpackage

// File: rtl/gr_addr_map.sv
module gr_addr_map
    import gr_pkg::*;
#(
    parameter int NR = NREGS,
    parameter int NN = NARROWN
) (
    input  idx_t  addr,
    input  view_e view,
    output idx_t  idx,
    output logic  is_zero
);
    localparam int NB = $clog2(NN);
    localparam idx_t ZIDX = idx_t'(NR - 1);

    always_comb begin
        if (view == VIEW_NARROW) begin
            idx = idx_t'(addr[NB-1:0]);
        end else begin
            idx = addr;
        end
        is_zero = (idx == ZIDX);
    end
endmodule

// File: rtl/gr_storage.sv
module gr_storage
    import gr_pkg::*;
#(
    parameter int NR = NREGS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  wr,
    output logic [NR-1:0][XLEN-1:0]  bank
);
    localparam idx_t ZIDX = idx_t'(NR - 1);

    for (genvar i = 0; i < NR; i++) begin : g_ent
        if (i == NR - 1) begin : g_sink
            assign bank[i] = '0;
        end else begin : g_reg
            word_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr.en && wr.idx == idx_t'(i)) begin
                    q <= wr.val;
                end
            end
            assign bank[i] = q;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> bank == '0); // R1
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.idx != ZIDX) |=> bank[$past(wr.idx)] == $past(wr.val)); // R2
    AST_SINK_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.idx == ZIDX) |=> $stable(bank)); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(bank)); // R9
endmodule

// File: rtl/gr_read_port.sv
module gr_read_port
    import gr_pkg::*;
#(
    parameter int NR = NREGS,
    parameter int NN = NARROWN
) (
    input  logic [NR-1:0][XLEN-1:0] bank,
    input  idx_t                    addr,
    input  view_e                   view,
    output word_t                   data
);
    idx_t idx;
    logic is_zero;

    gr_addr_map #(.NR(NR), .NN(NN)) u_map (
        .addr(addr), .view(view), .idx(idx), .is_zero(is_zero)
    );

    always_comb begin
        if (view == VIEW_NARROW) begin
            data = reg_to_narrow(bank[idx]);
        end else if (is_zero) begin
            data = '0;
        end else begin
            data = bank[idx];
        end
    end
endmodule

// File: rtl/gr_dualview_file.sv
module gr_dualview_file
    import gr_pkg::*;
#(
    parameter int NR = NREGS,
    parameter int NN = NARROWN,
    localparam int AW = $clog2(NR)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   ra_addr,
    input  logic            ra_mode,
    output logic [XLEN-1:0] ra_data,
    input  logic [AW-1:0]   rb_addr,
    input  logic            rb_mode,
    output logic [XLEN-1:0] rb_data,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic            wr_mode,
    input  logic [XLEN-1:0] wr_data
);
    logic [NR-1:0][XLEN-1:0] bank;
    wr_req_t wreq;
    idx_t    widx;
    logic    wzero;

    gr_addr_map #(.NR(NR), .NN(NN)) u_wmap (
        .addr(wr_addr), .view(view_e'(wr_mode)), .idx(widx), .is_zero(wzero)
    );

    always_comb begin
        wreq.en  = wr_en;
        wreq.idx = widx;
        wreq.val = (view_e'(wr_mode) == VIEW_NARROW) ? narrow_to_reg(wr_data) : wr_data;
    end

    gr_storage #(.NR(NR)) u_store (
        .clk(clk), .rst(rst), .wr(wreq), .bank(bank)
    );

    gr_read_port #(.NR(NR), .NN(NN)) u_rpa (
        .bank(bank), .addr(ra_addr), .view(view_e'(ra_mode)), .data(ra_data)
    );

    gr_read_port #(.NR(NR), .NN(NN)) u_rpb (
        .bank(bank), .addr(rb_addr), .view(view_e'(rb_mode)), .data(rb_data)
    );

    AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
        (!ra_mode && ra_addr == AW'(NR - 1)) |-> ra_data == '0); // R3
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        rb_mode |-> rb_data[XLEN-1:NW] == '0); // R5
    AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode) |-> (widx < idx_t'(NN) && !wzero)); // R7
    AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode) |=> bank[$past(widx)][XLEN-1:NW] == {(XLEN-NW){$past(wr_data[NW-1])}}); // R6
endmodule

// File: tb/sim_gr_dualview_file.sv
module sim_gr_dualview_file;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  ra_addr = '0, rb_addr = '0, wr_addr = '0;
    logic        ra_mode = 1'b0, rb_mode = 1'b0, wr_mode = 1'b0, wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] ra_data, rb_data;

    logic [63:0] model [64];
    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    gr_dualview_file u0 (
        .clk(clk), .rst(rst),
        .ra_addr(ra_addr), .ra_mode(ra_mode), .ra_data(ra_data),
        .rb_addr(rb_addr), .rb_mode(rb_mode), .rb_data(rb_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_mode(wr_mode), .wr_data(wr_data)
    );

    function automatic int phys(input logic [5:0] a, input logic m);
        return m ? int'(a[3:0]) : int'(a);
    endfunction

    function automatic logic [63:0] exp_read(input logic [5:0] a, input logic m);
        int p = phys(a, m);
        if (p == 63) return 64'd0;
        return m ? {32'd0, model[p][31:0]} : model[p];
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // inputs already driven; check reads before edge, then apply edge to model
    task automatic cycle(input string ta, input string tb);
        #1;
        check(ta, ra_data, exp_read(ra_addr, ra_mode));
        check(tb, rb_data, exp_read(rb_addr, rb_mode));
        @(posedge clk);
        if (wr_en) begin
            int p = phys(wr_addr, wr_mode);
            if (p != 63)
                model[p] = wr_mode ? {{32{wr_data[31]}}, wr_data[31:0]} : wr_data;
        end
        @(negedge clk);
    endtask

    task automatic setw(input logic e, input logic [5:0] a, input logic m, input logic [63:0] d);
        wr_en = e; wr_addr = a; wr_mode = m; wr_data = d;
    endtask

    task automatic setr(input logic [5:0] a, input logic ma, input logic [5:0] b, input logic mb);
        ra_addr = a; ra_mode = ma; rb_addr = b; rb_mode = mb;
    endtask

    function automatic logic [5:0] rnd_addr();
        int s = int'($urandom_range(0, 3));
        if (s == 0) return 6'd63;
        if (s == 1) return 6'($urandom_range(0, 15));
        return 6'($urandom_range(0, 63));
    endfunction

    function automatic string tag_for(input logic [5:0] a, input logic m);
        if (m) return "R5/R7";
        if (a == 6'd63) return "R3";
        return "R2/R9";
    endfunction

    initial begin
        #(CLK_P * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 64; i++) model[i] = 64'd0;
        // scribble under reset: no write must survive R1
        setw(1'b1, 6'd7, 1'b0, 64'hdead_beef_0000_1111);
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
        setw(1'b0, 6'd0, 1'b0, 64'd0);
        for (int i = 0; i < 64; i += 2) begin
            setr(6'(i), 1'b0, 6'(i + 1), 1'b0);
            cycle("R1", "R1");
        end

        // R2 full write then read
        setw(1'b1, 6'd5, 1'b0, 64'h8123_4567_89ab_cdef);
        cycle("R2", "R2");
        setw(1'b0, 6'd0, 1'b0, 64'd0);
        setr(6'd5, 1'b0, 6'd5, 1'b1);
        cycle("R2", "R5");

        // R4 write to sink, then R3 read it back and neighbour unaffected
        setw(1'b1, 6'd63, 1'b0, 64'hffff_ffff_ffff_ffff);
        setr(6'd63, 1'b0, 6'd5, 1'b0);
        cycle("R3", "R4");
        setw(1'b0, 6'd0, 1'b0, 64'd0);
        cycle("R4", "R4");

        // R6 negative narrow write with junk upper bits, read in full view
        setw(1'b1, 6'd9, 1'b1, 64'h1234_5678_8000_0001);
        cycle("R6", "R6");
        setw(1'b0, 6'd0, 1'b0, 64'd0);
        setr(6'd9, 1'b0, 6'd9, 1'b1);
        #1;
        check("R6", ra_data, 64'hffff_ffff_8000_0001);
        check("R5", rb_data, 64'h0000_0000_8000_0001);
        cycle("R6", "R5");

        // R7 aliased narrow access: address 0x39 narrow -> register 9
        setr(6'h39, 1'b1, 6'h19, 1'b1);
        #1;
        check("R7", ra_data, 64'h0000_0000_8000_0001);
        cycle("R7", "R7");
        setw(1'b1, 6'h35, 1'b1, 64'h0000_0000_0000_7777);
        setr(6'd5, 1'b0, 6'd53, 1'b0);
        cycle("R7", "R7");
        setw(1'b0, 6'd0, 1'b0, 64'd0);
        #1;
        check("R7", ra_data, 64'h0000_0000_0000_7777);
        check("R7", rb_data, 64'd0);
        cycle("R7", "R7");

        // R8 same-cycle read/write returns old value, new value next cycle
        setw(1'b1, 6'd20, 1'b0, 64'h0bad_cafe_0bad_cafe);
        setr(6'd20, 1'b0, 6'd20, 1'b0);
        #1;
        check("R8", ra_data, 64'd0);
        cycle("R8", "R8");
        setw(1'b0, 6'd0, 1'b0, 64'd0);
        #1;
        check("R8", rb_data, 64'h0bad_cafe_0bad_cafe);
        cycle("R8", "R8");

        // R9 write disabled: data on bus must not land
        setw(1'b0, 6'd20, 1'b0, 64'h1111_2222_3333_4444);
        cycle("R9", "R9");
        #1;
        check("R9", ra_data, 64'h0bad_cafe_0bad_cafe);

        // random mix
        for (int k = 0; k < 4000; k++) begin
            logic [5:0] a = rnd_addr();
            logic [5:0] b = rnd_addr();
            logic ma = 1'($urandom_range(0, 1));
            logic mb = 1'($urandom_range(0, 1));
            setr(a, ma, b, mb);
            setw(($urandom_range(0, 3) != 0), rnd_addr(), 1'($urandom_range(0, 1)),
                 {$urandom(), $urandom()});
            if ($urandom_range(0, 7) == 0) wr_addr = a;
            cycle(tag_for(a, ma), tag_for(b, mb));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule